// File: doc/BRIEF.md
# Serial Register Port with Shared Data/Ready Output

This block is the host-facing serial slave of a measurement converter. A host drives a serial clock, an active-low select and a data input; the block answers on one output line that carries read data while a register read is under way and a conversion-ready flag at all other times. The serial pins are resynchronised to the system clock and their edges are detected there. Every transaction opens with an 8-bit command byte. The byte names one of a handful of internal registers and says whether the following bits load it or read it back.

The converter side presents a strobe with each new 24-bit offset-binary result, and a warning strobe shortly before the next result lands. The ready flag rises on a result. It drops when the data register has been read out in full, when the warning arrives first, or while the synchronisation input is held low. A result that arrives during a data-register read is parked until that read ends, so the word being shifted out is never mixed. A continuous-read option lets the host take each result with bare clock bursts and no command byte.

The block has two 24-bit settings registers, named mode and setup, and drives them straight to the converter. It also has a status byte, a read-only identity byte and the read-only data register.

Top module: `ser_reg_port`

## Requirements
- R1: While cs_n is high, dout_oe is 0 within 3 clock cycles. While cs_n is low, dout_oe is 1, and outside a read's data bits dout_rdy shows the inverted ready flag (0 = a result is waiting).
- R2: Command byte, MSB first: bit 7 must be 0, bit 6 is the direction (1 = read), bits 5:3 select the register (0 status, 1 mode, 2 setup, 3 data, 4 identity) and bit 2 requests continuous read. Writes to mode (0x08) and setup (0x10) take 24 bits MSB first, sampled on sclk rising edges. They appear on mode_q/setup_q and read back unchanged through 0x48/0x50.
- R3: Read bits leave MSB first. Each bit changes after an sclk falling edge and is stable at the next rising edge. The data (0x58) and mode/setup reads are 24 bits; status (0x40) and identity (0x60) are 8 bits. Identity reads DEV_ID.
- R4: A conv_stb pulse loads conv_val into the data register and sets ready, which drives dout_rdy low. The status byte is {~ready, continuous-read, 6'b0}.
- R5: When all 24 bits of a data-register read have completed, ready clears. A further data read while ready is clear returns the same word.
- R6: A conv_warn pulse clears ready without changing the data register.
- R7: While sync_n is low, ready is held clear. Serial transactions still complete normally.
- R8: A conv_stb during a data-register read leaves the word being shifted unchanged. At the end of that read, the new value is loaded and ready is set.
- R9: After command 0x5C, continuous read is on. Each result is shifted out once, as 24 bits, with no command byte. Clock bursts while ready is clear give all ones, and DIN is not decoded.
- R10: 32 consecutive ones sampled on DIN return the interface to waiting for a command and turn continuous read off. The mode and setup contents are kept.
- R11: cs_n going high in the middle of a transaction abandons it, and the register being written keeps its old value.
- R12: A command byte with bit 7 set is discarded. Writes to status, data or identity consume their bits and change nothing. Select codes 5 to 7 have no data phase.
- R13: After reset, ready is clear, dout_oe is 0, mode_q equals MODE_RST and setup_q equals SETUP_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, idles high |
| cs_n | input | 1 | Active-low select and framing |
| din | input | 1 | Serial data from host |
| dout_rdy | output | 1 | Shared read-data / ready-flag line (ready active low) |
| dout_oe | output | 1 | Drive enable for dout_rdy |
| conv_stb | input | 1 | One-cycle pulse: a new result is valid |
| conv_val | input | DW | New result, offset binary |
| conv_warn | input | 1 | One-cycle pulse: next result is about to land |
| sync_n | input | 1 | Active-low synchronisation hold |
| mode_q | output | DW | Mode settings register |
| setup_q | output | DW | Setup settings register |

## Verification
If the bit counter or phase is wrong, the block misframes the next command byte. The host then sees the wrong word on the very next readback, often with the ready level showing where data bits should be. A wrong ready flag shows up on dout_rdy within two cycles of the strobe, warning, sync change or read completion that should have moved it. A mishandled parked result shows up as a corrupted word in the read that was in flight, or as a missing ready after that read ends. The output-enable path is compared against the select pin on every clock.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} phase_t;

  localparam int CMD_W   = 8;
  localparam int C_GUARD = 7;
  localparam int C_DIR   = 6;
  localparam int C_SEL_H = 5;
  localparam int C_SEL_L = 3;
  localparam int C_CONT  = 2;

  localparam logic [2:0] SEL_STAT  = 3'd0;
  localparam logic [2:0] SEL_MODE  = 3'd1;
  localparam logic [2:0] SEL_SETUP = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_ID    = 3'd4;

  // data-phase length of each selectable register; 0 means no data phase
  function automatic int word_bits(input logic [2:0] s, input int dw);
    case (s)
      SEL_MODE, SEL_SETUP, SEL_DATA: return dw;
      SEL_STAT, SEL_ID:              return CMD_W;
      default:                       return 0;
    endcase
  endfunction
endpackage

// File: rtl/ser_reg_sync.sv
module ser_reg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk) r[g] <= rst ? RST_VAL : d;
    end else begin : g_next
      always_ff @(posedge clk) r[g] <= rst ? RST_VAL : r[g-1];
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/ser_reg_ready.sv
module ser_reg_ready #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_stb,
  input  logic [DW-1:0] conv_val,
  input  logic          conv_warn,
  input  logic          sync_n,
  input  logic          rd_busy,
  input  logic          rd_done,
  output logic [DW-1:0] data_q,
  output logic          rdy
);
  logic          pend;
  logic [DW-1:0] pend_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy      <= 1'b0;
      data_q   <= '0;
      pend     <= 1'b0;
      pend_val <= '0;
    end else begin
      if (rd_done) begin
        pend <= 1'b0;
        if (conv_stb) begin
          data_q <= conv_val;
          rdy    <= 1'b1;
        end else if (pend) begin
          data_q <= pend_val;
          rdy    <= 1'b1;
        end else begin
          rdy <= 1'b0;
        end
      end else if (rd_busy) begin
        if (conv_stb) begin
          pend     <= 1'b1;
          pend_val <= conv_val;
        end else if (conv_warn) begin
          rdy <= 1'b0;
        end
      end else begin
        if (conv_stb) begin
          data_q <= conv_val;
          rdy    <= 1'b1;
          pend   <= 1'b0;
        end else if (pend) begin
          data_q <= pend_val;
          rdy    <= 1'b1;
          pend   <= 1'b0;
        end else if (conv_warn) begin
          rdy <= 1'b0;
        end
      end
      if (!sync_n) rdy <= 1'b0;
    end
  end

  // R7: sync hold keeps ready clear
  a_r7_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> !rdy);
  // R8: result register frozen during a data read
  a_r8_no_tear: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && !rd_done) |=> $stable(data_q));
  // R5: completed read with nothing parked clears ready
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !conv_stb && !pend) |=> !rdy);
  // R4: fresh result outside a read sets ready
  a_r4_result_sets: assert property (@(posedge clk) disable iff (rst)
    (conv_stb && !rd_busy && sync_n) |=> rdy);
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import ser_reg_pkg::*;
#(
  parameter int          DW          = 24,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_ONES    = 32,
  parameter logic [23:0] MODE_RST    = 24'h080060,
  parameter logic [23:0] SETUP_RST   = 24'h000117,
  parameter logic [7:0]  DEV_ID      = 8'hA4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  output logic          dout_rdy,
  output logic          dout_oe,
  input  logic          conv_stb,
  input  logic [DW-1:0] conv_val,
  input  logic          conv_warn,
  input  logic          sync_n,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] setup_q
);
  localparam int CNT_W  = $clog2(DW + 1);
  localparam int ONES_W = $clog2(RST_ONES + 1);
  localparam int PAD    = DW - CMD_W;

  logic sclk_s, cs_s, din_s, sclk_q;
  logic rise, fall, ones_hit, cont_go, rd_busy, rd_done;
  phase_t state;
  logic [CNT_W-1:0] cnt, last;
  logic [2:0] sel;
  logic [DW-1:0] sh, data_q, pick;
  logic [ONES_W-1:0] ones;
  logic cread, bitq, drv, rdy;
  logic [CMD_W-1:0] cmd_w;
  logic [2:0] cmd_sel;

  ser_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck (.clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
  ser_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csn (.clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  ser_reg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din (.clk(clk), .rst(rst), .d(din), .q(din_s));

  always_ff @(posedge clk) sclk_q <= rst ? 1'b1 : sclk_s;

  assign rise     = sclk_s & ~sclk_q & ~cs_s;
  assign fall     = ~sclk_s & sclk_q & ~cs_s;
  assign ones_hit = rise && din_s && (ones == ONES_W'(RST_ONES - 1));
  assign cmd_w    = {sh[CMD_W-2:0], din_s};
  assign cmd_sel  = cmd_w[C_SEL_H:C_SEL_L];
  assign rd_busy  = (state == ST_RD) && (sel == SEL_DATA);
  assign rd_done  = rd_busy && rise && (cnt == last) && !cs_s;
  assign cont_go  = (state == ST_CMD) && cread && rdy && !cs_s && (cnt == '0);

  always_comb begin
    unique case (cmd_sel)
      SEL_MODE:  pick = mode_q;
      SEL_SETUP: pick = setup_q;
      SEL_DATA:  pick = data_q;
      SEL_STAT:  pick = {~rdy, cread, 6'b0, {PAD{1'b0}}};
      default:   pick = {DEV_ID, {PAD{1'b0}}};
    endcase
  end

  ser_reg_ready #(.DW(DW)) u_rdy (
    .clk(clk), .rst(rst), .conv_stb(conv_stb), .conv_val(conv_val),
    .conv_warn(conv_warn), .sync_n(sync_n), .rd_busy(rd_busy),
    .rd_done(rd_done), .data_q(data_q), .rdy(rdy));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CMD;
      cnt     <= '0;
      last    <= '0;
      sel     <= SEL_STAT;
      sh      <= '0;
      cread   <= 1'b0;
      ones    <= '0;
      bitq    <= 1'b1;
      drv     <= 1'b0;
      mode_q  <= MODE_RST[DW-1:0];
      setup_q <= SETUP_RST[DW-1:0];
    end else begin
      if (rise) ones <= (din_s && !ones_hit) ? ones + 1'b1 : '0;
      if (cs_s) begin
        state <= ST_CMD;
        cnt   <= '0;
        drv   <= 1'b0;
      end else if (ones_hit) begin
        state <= ST_CMD;
        cnt   <= '0;
        cread <= 1'b0;
        drv   <= 1'b0;
      end else begin
        unique case (state)
          ST_CMD: begin
            if (cont_go) begin
              sel   <= SEL_DATA;
              last  <= CNT_W'(DW - 1);
              sh    <= data_q;
              state <= ST_RD;
            end else if (rise && !cread) begin
              sh <= {sh[DW-2:0], din_s};
              if (cnt == CNT_W'(CMD_W - 1)) begin
                cnt <= '0;
                if (!cmd_w[C_GUARD]) begin
                  sel  <= cmd_sel;
                  last <= CNT_W'(word_bits(cmd_sel, DW) - 1);
                  if (cmd_w[C_DIR] && cmd_sel == SEL_DATA && cmd_w[C_CONT]) begin
                    cread <= 1'b1;
                  end else if (word_bits(cmd_sel, DW) != 0) begin
                    if (cmd_w[C_DIR]) begin
                      state <= ST_RD;
                      sh    <= pick;
                    end else begin
                      state <= ST_WR;
                    end
                  end
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_WR: begin
            if (rise) begin
              sh <= {sh[DW-2:0], din_s};
              if (cnt == last) begin
                cnt   <= '0;
                state <= ST_CMD;
                if (sel == SEL_MODE)  mode_q  <= {sh[DW-2:0], din_s};
                if (sel == SEL_SETUP) setup_q <= {sh[DW-2:0], din_s};
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            if (fall) begin
              bitq <= sh[DW-1];
              drv  <= 1'b1;
            end
            if (rise) begin
              sh <= {sh[DW-2:0], 1'b0};
              if (cnt == last) begin
                cnt   <= '0;
                state <= ST_CMD;
                drv   <= 1'b0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_rdy <= 1'b1;
      dout_oe  <= 1'b0;
    end else begin
      dout_rdy <= drv ? bitq : ~rdy;
      dout_oe  <= ~cs_s;
    end
  end

  // R1: deselect disables the output driver
  a_r1_oe_off: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !dout_oe);
  // R10: run of ones forces command wait and ends continuous read
  a_r10_ones_exit: assert property (@(posedge clk) disable iff (rst)
    (ones_hit && !cs_s) |=> (state == ST_CMD && !cread && cnt == '0));
  // R12: guarded command byte opens no data phase
  a_r12_guard_drop: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD && rise && !cread && !cs_s && !ones_hit &&
     cnt == CNT_W'(CMD_W - 1) && cmd_w[C_GUARD]) |=> (state == ST_CMD && cnt == '0));
  // R11: deselect abandons any transaction
  a_r11_abort: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (state == ST_CMD && !drv));
endmodule

// File: tb/test_ser_reg_port.sv
`timescale 1ns/1ps
module test_ser_reg_port;
  localparam int H = 8;
  localparam logic [23:0] MODE_RST  = 24'h080060;
  localparam logic [23:0] SETUP_RST = 24'h000117;
  localparam logic [7:0]  DEV_ID    = 8'hA4;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic conv_stb = 1'b0, conv_warn = 1'b0, sync_n = 1'b1;
  logic [23:0] conv_val = '0;
  logic dout_rdy, dout_oe;
  logic [23:0] mode_q, setup_q;

  int checks = 0, fails = 0;
  bit done = 1'b0, live = 1'b0;
  logic d1 = 1'b1, d2 = 1'b1, d3 = 1'b1;
  logic [23:0] mode_m, setup_m, data_m, v;

  always #2.5 clk = ~clk;

  ser_reg_port i_ser_reg_port (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout_rdy(dout_rdy), .dout_oe(dout_oe), .conv_stb(conv_stb),
    .conv_val(conv_val), .conv_warn(conv_warn), .sync_n(sync_n),
    .mode_q(mode_q), .setup_q(setup_q));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R1 reference: enable follows select pin three clocks later, every clock
  always @(negedge clk) begin
    if (live) chk("R1 oe per clock", {31'b0, dout_oe}, {31'b0, ~d3});
    d3 = d2; d2 = d1; d1 = cs_n;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = val[i]; tick(H);
      sclk = 1'b1; tick(H);
    end
    din = 1'b0;
  endtask

  task automatic rd_bits(input int n, input int inj, input logic [23:0] ival, output logic [23:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; din = 1'b0;
      if (i == inj) begin
        tick(2); conv_val = ival; conv_stb = 1'b1; tick(1); conv_stb = 1'b0; tick(H - 3);
      end else tick(H);
      r = {r[22:0], dout_rdy};
      sclk = 1'b1; tick(H);
    end
  endtask

  task automatic result(input logic [23:0] val);
    conv_val = val; conv_stb = 1'b1; tick(1); conv_stb = 1'b0; tick(3);
  endtask

  initial begin
    tick(4); rst = 1'b0; tick(2);
    live = 1'b1;
    // R13 reset state
    chk("R13 oe", {31'b0, dout_oe}, 32'd0);
    chk("R13 mode", {8'b0, mode_q}, {8'b0, MODE_RST});
    chk("R13 setup", {8'b0, setup_q}, {8'b0, SETUP_RST});
    mode_m = MODE_RST; setup_m = SETUP_RST;
    cs_n = 1'b0; tick(6);
    chk("R1 line shows not-ready", {31'b0, dout_rdy}, 32'd1);

    // R2 writes and readback
    mode_m = 24'h123456; send_bits(8'h08, 8); send_bits({8'b0, mode_m}, 24); tick(2);
    chk("R2 mode port", {8'b0, mode_q}, {8'b0, mode_m});
    send_bits(8'h48, 8); rd_bits(24, -1, 0, v); chk("R2 mode readback", {8'b0, v}, {8'b0, mode_m});
    setup_m = 24'hA5C33C; send_bits(8'h10, 8); send_bits({8'b0, setup_m}, 24);
    send_bits(8'h50, 8); rd_bits(24, -1, 0, v); chk("R2 setup readback", {8'b0, v}, {8'b0, setup_m});

    // R3 identity byte
    send_bits(8'h60, 8); rd_bits(8, -1, 0, v); chk("R3 identity", {24'b0, v[7:0]}, {24'b0, DEV_ID});

    // R4 result sets ready; status byte
    data_m = 24'h800123; result(data_m);
    chk("R4 line low on result", {31'b0, dout_rdy}, 32'd0);
    send_bits(8'h40, 8); rd_bits(8, -1, 0, v); chk("R4 status", {24'b0, v[7:0]}, 32'h00);

    // R3/R5 data read clears ready, re-read same
    send_bits(8'h58, 8); rd_bits(24, -1, 0, v); tick(3);
    chk("R3 data word", {8'b0, v}, {8'b0, data_m});
    chk("R5 ready cleared", {31'b0, dout_rdy}, 32'd1);
    send_bits(8'h58, 8); rd_bits(24, -1, 0, v); tick(3);
    chk("R5 re-read same", {8'b0, v}, {8'b0, data_m});

    // R6 warning clears unread result
    data_m = 24'h7FFFFF; result(data_m);
    conv_warn = 1'b1; tick(1); conv_warn = 1'b0; tick(3);
    chk("R6 warn clears ready", {31'b0, dout_rdy}, 32'd1);
    send_bits(8'h58, 8); rd_bits(24, -1, 0, v); chk("R6 data kept", {8'b0, v}, {8'b0, data_m});

    // R7 sync hold
    data_m = 24'h000001; result(data_m);
    sync_n = 1'b0; tick(3);
    chk("R7 sync forces not-ready", {31'b0, dout_rdy}, 32'd1);
    mode_m = 24'h0F0F0F; send_bits(8'h08, 8); send_bits({8'b0, mode_m}, 24);
    send_bits(8'h48, 8); rd_bits(24, -1, 0, v); chk("R7 interface alive", {8'b0, v}, {8'b0, mode_m});
    sync_n = 1'b1; tick(3);
    chk("R7 stays not-ready", {31'b0, dout_rdy}, 32'd1);

    // R8 result during data read is parked
    send_bits(8'h58, 8); rd_bits(24, 10, 24'hABCDEF, v); tick(3);
    chk("R8 word untorn", {8'b0, v}, {8'b0, data_m});
    chk("R8 ready after read", {31'b0, dout_rdy}, 32'd0);
    data_m = 24'hABCDEF;
    send_bits(8'h58, 8); rd_bits(24, -1, 0, v); tick(3);
    chk("R8 parked value", {8'b0, v}, {8'b0, data_m});

    // R12 guarded byte, read-only write, no-phase select
    send_bits(8'h88, 8);
    send_bits(8'h48, 8); rd_bits(24, -1, 0, v); chk("R12 guard discarded", {8'b0, v}, {8'b0, mode_m});
    send_bits(8'h20, 8); send_bits(32'h00, 8);
    send_bits(8'h60, 8); rd_bits(8, -1, 0, v); chk("R12 identity read-only", {24'b0, v[7:0]}, {24'b0, DEV_ID});
    send_bits(8'h78, 8);
    send_bits(8'h50, 8); rd_bits(24, -1, 0, v); chk("R12 select 7 no phase", {8'b0, v}, {8'b0, setup_m});

    // R11 abort mid-write
    send_bits(8'h08, 8); send_bits(32'h0, 12);
    cs_n = 1'b1; tick(8); cs_n = 1'b0; tick(6);
    send_bits(8'h48, 8); rd_bits(24, -1, 0, v); chk("R11 write abandoned", {8'b0, v}, {8'b0, mode_m});

    // R9 continuous read
    send_bits(8'h5C, 8);
    data_m = 24'h13579B; result(data_m);
    chk("R9 ready low", {31'b0, dout_rdy}, 32'd0);
    rd_bits(24, -1, 0, v); tick(3);
    chk("R9 burst word", {8'b0, v}, {8'b0, data_m});
    rd_bits(24, -1, 0, v);
    chk("R9 read once only", {8'b0, v}, 32'h00FFFFFF);
    data_m = 24'h2468AC; result(data_m);
    rd_bits(24, -1, 0, v); tick(3);
    chk("R9 next burst", {8'b0, v}, {8'b0, data_m});

    // R10 run of ones exits
    send_bits(32'hFFFFFFFF, 32);
    data_m = 24'h0000AA; result(data_m);
    send_bits(8'h48, 8); rd_bits(24, -1, 0, v); chk("R10 commands decoded", {8'b0, v}, {8'b0, mode_m});
    chk("R10 mode kept", {8'b0, mode_q}, {8'b0, mode_m});
    send_bits(8'h58, 8); rd_bits(24, -1, 0, v); chk("R10 data via command", {8'b0, v}, {8'b0, data_m});

    cs_n = 1'b1; tick(5);
    chk("R1 oe off at end", {31'b0, dout_oe}, 32'd0);
    live = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule